// File: doc/BRIEF.md
# String Compare Step Unit

This block carries out a single iteration of a memory-to-memory string comparison. The two operands have already been fetched by the surrounding pipeline. The block receives them together with the operand size, the direction flag, the address-size mode, the two current pointers and the segment attributes that govern those pointers. It subtracts the second operand from the first and discards the difference. The only architectural effects are the six arithmetic status flags, which are derived from the difference, and a step of both pointers by the operand size, forward or backward.

Before any state commits, the block checks both operand references for a null data-segment selector, for a segment-limit overrun and, when enabled at user privilege, for misalignment. A detected fault suppresses every update and is reported with an encoded fault kind. An operation is requested with a one-cycle start pulse. One clock later a done pulse appears with the new pointers, the flag vector and the fault status.

Top module: `strcmp_step`

## Requirements
- R1: The flag vector `flags_o` is {OF, SF, ZF, AF, PF, CF} from bit 5 down to bit 0. It is computed from opa minus opb taken at the selected width N (8, 16 or 32). Operand bits above N are ignored. CF is the borrow out of bit N-1, SF is result bit N-1, ZF is set for an all-zero N-bit result, and OF is signed overflow of the N-bit subtraction.
- R2: AF is the borrow out of bit 3 of the subtraction, and PF is set when the low 8 bits of the difference have even parity. Both rules apply at every width.
- R3: `size_i` encodes 0 = byte (step 1), 1 = word (step 2), 2 or 3 = doubleword (step 4). With `dir_i` = 0 both pointers are increased by the step, and with `dir_i` = 1 both are decreased.
- R4: With `addr32_i` = 0, only the low 16 bits of each pointer take part in the step, wrapping modulo 2^16, and bits 31:16 are passed through unchanged. The low 16 bits alone also form the effective address for the fault checks. With `addr32_i` = 1 the full 32-bit pointer is stepped and used.
- R5: If `src_null_i` or `dst_null_i` is set, the operation reports a general-protection fault, code 1. This check has top priority.
- R6: A reference overruns its limit when its effective address plus the step minus 1 exceeds the limit. A source overrun reports a stack fault (code 2) when `src_stk_i` is set, and code 1 otherwise. A destination overrun reports code 1. The source overrun is checked before the destination overrun.
- R7: When `ac_en_i` = 1 and `cpl_i` = 3, an effective address that is not a multiple of the step reports an alignment fault, code 3. This check has the lowest priority, and no alignment fault is raised under any other privilege level or with checking disabled.
- R8: A faulting operation leaves `flags_o` at its previous value and returns the input pointers unchanged on `src_ptr_o`/`dst_ptr_o`. `fault_o` is high and `fault_code_o` is nonzero together with `done_o`. A clean operation reports `fault_o` = 0 and code 0.
- R9: `done_o` is high for exactly the one cycle after each cycle with `start_i` high, and is low at all other times.
- R10: After synchronous reset, `done_o`, `fault_o`, `fault_code_o`, `flags_o` and both pointer outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request carrying the operands |
| size_i | input | 2 | Operand size code |
| dir_i | input | 1 | Direction: 0 forward, 1 backward |
| addr32_i | input | 1 | 1 = 32-bit addressing, 0 = 16-bit |
| opa_i | input | 32 | First operand (minuend) |
| opb_i | input | 32 | Second operand (subtrahend) |
| src_ptr_i | input | 32 | Current source pointer |
| dst_ptr_i | input | 32 | Current destination pointer |
| src_lim_i | input | 32 | Limit of the source segment |
| dst_lim_i | input | 32 | Limit of the destination segment |
| src_null_i | input | 1 | Source data segment holds a null selector |
| dst_null_i | input | 1 | Destination segment holds a null selector |
| src_stk_i | input | 1 | Source reference goes through the stack segment |
| ac_en_i | input | 1 | Alignment checking enabled |
| cpl_i | input | 2 | Current privilege level |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 1 | Operation faulted |
| fault_code_o | output | 2 | 0 none, 1 general protection, 2 stack, 3 alignment |
| flags_o | output | 6 | Status flags {OF,SF,ZF,AF,PF,CF} |
| src_ptr_o | output | 32 | Updated source pointer |
| dst_ptr_o | output | 32 | Updated destination pointer |

## Verification
The compare is tried on three kinds of operand pair. Equal pairs must give ZF and PF. Pairs whose difference crosses the sign boundary must give OF without CF or CF without OF, which tells signed overflow apart from unsigned borrow. Pairs with junk above the selected width show whether narrow compares really mask the upper bits. Each of the three sizes is run in both directions, and a 16-bit pointer sits on the 0xFFFF/0x0000 seam, so that a wrong step size, sign or carry into bit 16 shows up in the pointers. The fault patterns place a reference exactly on the limit and one byte past it, make a null selector coincide with an overrun, and toggle alignment checking against privilege level. Each of these separates one priority or condition from its neighbours, and each confirms that flags and pointers stay frozen.

// File: rtl/strcmp_pkg.sv
package strcmp_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_DWALT = 2'd3
    } opsize_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_SS   = 2'd2,
        FLT_AC   = 2'd3
    } fault_e;

    // bit order matches the flags_o port: {OF,SF,ZF,AF,PF,CF}
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } flags_t;

    localparam int NUM_CH = 2;  // channel 0 = source, 1 = destination

    function automatic logic [2:0] step_bytes(opsize_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_WORD: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/strcmp_flag_unit.sv
module strcmp_flag_unit
    import strcmp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  opsize_e             size,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    output flags_t              flags
);
    localparam int N_W = 3;

    flags_t     per_w [N_W];
    logic [4:0] nib_diff;
    logic [7:0] low_res;

    assign nib_diff = {1'b0, opa[3:0]} - {1'b0, opb[3:0]};
    assign low_res  = opa[7:0] - opb[7:0];

    for (genvar w = 0; w < N_W; w++) begin : g_width
        localparam int W = 8 << w;
        logic [W:0] diff;
        assign diff = {1'b0, opa[W-1:0]} - {1'b0, opb[W-1:0]};
        assign per_w[w] = '{
            ovf: (opa[W-1] ^ opb[W-1]) & (diff[W-1] ^ opa[W-1]),
            sgn: diff[W-1],
            zro: (diff[W-1:0] == '0),
            aux: nib_diff[4],
            par: ~^low_res,
            cry: diff[W]
        };
    end

    always_comb begin
        case (size)
            SZ_BYTE: flags = per_w[0];
            SZ_WORD: flags = per_w[1];
            default: flags = per_w[2];
        endcase
    end

endmodule

// File: rtl/strcmp_ptr_step.sv
module strcmp_ptr_step
    import strcmp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] ptr,
    input  opsize_e           size,
    input  logic              dir,
    input  logic              addr32,
    output logic [ADDR_W-1:0] ptr_nx
);
    logic [2:0]        step;
    logic [ADDR_W-1:0] full_nx;
    logic [15:0]       lo_nx;

    assign step    = step_bytes(size);
    assign full_nx = dir ? ptr - ADDR_W'(step) : ptr + ADDR_W'(step);
    assign lo_nx   = dir ? ptr[15:0] - 16'(step) : ptr[15:0] + 16'(step);
    assign ptr_nx  = addr32 ? full_nx : {ptr[ADDR_W-1:16], lo_nx};

endmodule

// File: rtl/strcmp_fault_chk.sv
module strcmp_fault_chk
    import strcmp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [NUM_CH-1:0][ADDR_W-1:0] ptr,
    input  logic [NUM_CH-1:0][ADDR_W-1:0] lim,
    input  logic [NUM_CH-1:0]             null_sel,
    input  logic [NUM_CH-1:0]             stk_seg,
    input  opsize_e                       size,
    input  logic                          addr32,
    input  logic                          ac_en,
    input  logic [1:0]                    cpl,
    output fault_e                        fault
);
    logic [2:0]        step;
    logic [NUM_CH-1:0] over;
    logic [NUM_CH-1:0] misal;

    assign step = step_bytes(size);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [ADDR_W-1:0] ea;
        logic [ADDR_W:0]   last;
        assign ea       = addr32 ? ptr[c] : {{(ADDR_W-16){1'b0}}, ptr[c][15:0]};
        assign last     = {1'b0, ea} + (ADDR_W+1)'(step - 3'd1);
        assign over[c]  = last > {1'b0, lim[c]};
        assign misal[c] = (ea[1:0] & (step[1:0] - 2'd1)) != 2'd0;
    end

    always_comb begin
        if (|null_sel)
            fault = FLT_GP;
        else if (over[0])
            fault = stk_seg[0] ? FLT_SS : FLT_GP;
        else if (over[1])
            fault = stk_seg[1] ? FLT_SS : FLT_GP;
        else if (ac_en && cpl == 2'd3 && (|misal))
            fault = FLT_AC;
        else
            fault = FLT_NONE;
    end

endmodule

// File: rtl/strcmp_step.sv
module strcmp_step
    import strcmp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        size_i,
    input  logic              dir_i,
    input  logic              addr32_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [ADDR_W-1:0] src_ptr_i,
    input  logic [ADDR_W-1:0] dst_ptr_i,
    input  logic [ADDR_W-1:0] src_lim_i,
    input  logic [ADDR_W-1:0] dst_lim_i,
    input  logic              src_null_i,
    input  logic              dst_null_i,
    input  logic              src_stk_i,
    input  logic              ac_en_i,
    input  logic [1:0]        cpl_i,
    output logic              done_o,
    output logic              fault_o,
    output logic [1:0]        fault_code_o,
    output logic [5:0]        flags_o,
    output logic [ADDR_W-1:0] src_ptr_o,
    output logic [ADDR_W-1:0] dst_ptr_o
);
    opsize_e                       size;
    flags_t                        nx_flags;
    fault_e                        nx_fault;
    logic [NUM_CH-1:0][ADDR_W-1:0] ptr_in;
    logic [NUM_CH-1:0][ADDR_W-1:0] lim_in;
    logic [NUM_CH-1:0][ADDR_W-1:0] ptr_nx;
    flags_t                        flags_q;

    assign size   = opsize_e'(size_i);
    assign ptr_in = {dst_ptr_i, src_ptr_i};
    assign lim_in = {dst_lim_i, src_lim_i};

    strcmp_flag_unit #(.DATA_W(DATA_W)) u_flags (
        .size  (size),
        .opa   (opa_i),
        .opb   (opb_i),
        .flags (nx_flags)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_step
        strcmp_ptr_step #(.ADDR_W(ADDR_W)) u_step (
            .ptr    (ptr_in[c]),
            .size   (size),
            .dir    (dir_i),
            .addr32 (addr32_i),
            .ptr_nx (ptr_nx[c])
        );
    end

    strcmp_fault_chk #(.ADDR_W(ADDR_W)) u_fault (
        .ptr      (ptr_in),
        .lim      (lim_in),
        .null_sel ({dst_null_i, src_null_i}),
        .stk_seg  ({1'b0, src_stk_i}),
        .size     (size),
        .addr32   (addr32_i),
        .ac_en    (ac_en_i),
        .cpl      (cpl_i),
        .fault    (nx_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o       <= 1'b0;
            fault_o      <= 1'b0;
            fault_code_o <= FLT_NONE;
            flags_q      <= '0;
            src_ptr_o    <= '0;
            dst_ptr_o    <= '0;
        end else begin
            done_o       <= start_i;
            fault_o      <= start_i && (nx_fault != FLT_NONE);
            fault_code_o <= start_i ? nx_fault : FLT_NONE;
            if (start_i) begin
                if (nx_fault == FLT_NONE) begin
                    flags_q   <= nx_flags;
                    src_ptr_o <= ptr_nx[0];
                    dst_ptr_o <= ptr_nx[1];
                end else begin
                    src_ptr_o <= src_ptr_i;
                    dst_ptr_o <= dst_ptr_i;
                end
            end
        end
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/strcmp_step_chk.sv
module strcmp_step_chk (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic [1:0]  size_i,
    input logic        dir_i,
    input logic        addr32_i,
    input logic [31:0] src_ptr_i,
    input logic        src_null_i,
    input logic        dst_null_i,
    input logic        ac_en_i,
    input logic [1:0]  cpl_i,
    input logic        done_o,
    input logic        fault_o,
    input logic [1:0]  fault_code_o,
    input logic [5:0]  flags_o,
    input logic [31:0] src_ptr_o
);
    a_r9_done_after_start: assert property (@(posedge clk) disable iff (rst)
        start_i |=> done_o);

    a_r9_done_needs_start: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(start_i));

    a_r1_zero_result: assert property (@(posedge clk) disable iff (rst)
        (done_o && !fault_o && flags_o[3]) |-> (!flags_o[0] && !flags_o[4] && flags_o[1]));

    a_r3_byte_step: assert property (@(posedge clk) disable iff (rst)
        (done_o && !fault_o && $past(addr32_i) && $past(size_i) == 2'd0)
        |-> src_ptr_o == ($past(dir_i) ? $past(src_ptr_i) - 32'd1 : $past(src_ptr_i) + 32'd1));

    a_r4_upper_kept: assert property (@(posedge clk) disable iff (rst)
        (done_o && !$past(addr32_i)) |-> src_ptr_o[31:16] == $past(src_ptr_i[31:16]));

    a_r5_null_gp: assert property (@(posedge clk) disable iff (rst)
        (done_o && $past(src_null_i || dst_null_i)) |-> fault_code_o == 2'd1);

    a_r7_ac_user_only: assert property (@(posedge clk) disable iff (rst)
        (done_o && fault_code_o == 2'd3) |-> ($past(ac_en_i) && $past(cpl_i) == 2'd3));

    a_r8_fault_freezes_flags: assert property (@(posedge clk) disable iff (rst)
        (done_o && fault_o) |-> $stable(flags_o));

    a_r8_fault_code_pairing: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> (done_o && fault_code_o != 2'd0));
endmodule

bind strcmp_step strcmp_step_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .size_i       (size_i),
    .dir_i        (dir_i),
    .addr32_i     (addr32_i),
    .src_ptr_i    (src_ptr_i),
    .src_null_i   (src_null_i),
    .dst_null_i   (dst_null_i),
    .ac_en_i      (ac_en_i),
    .cpl_i        (cpl_i),
    .done_o       (done_o),
    .fault_o      (fault_o),
    .fault_code_o (fault_code_o),
    .flags_o      (flags_o),
    .src_ptr_o    (src_ptr_o)
);

// File: tb/strcmp_step_bench.sv
module strcmp_step_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [1:0]  size_i;
    logic        dir_i, addr32_i;
    logic [31:0] opa_i, opb_i, src_ptr_i, dst_ptr_i, src_lim_i, dst_lim_i;
    logic        src_null_i, dst_null_i, src_stk_i, ac_en_i;
    logic [1:0]  cpl_i;
    logic        done_o, fault_o;
    logic [1:0]  fault_code_o;
    logic [5:0]  flags_o;
    logic [31:0] src_ptr_o, dst_ptr_o;

    always #5 clk = ~clk;

    strcmp_step u_strcmp_step (
        .clk(clk), .rst(rst), .start_i(start_i), .size_i(size_i), .dir_i(dir_i),
        .addr32_i(addr32_i), .opa_i(opa_i), .opb_i(opb_i),
        .src_ptr_i(src_ptr_i), .dst_ptr_i(dst_ptr_i),
        .src_lim_i(src_lim_i), .dst_lim_i(dst_lim_i),
        .src_null_i(src_null_i), .dst_null_i(dst_null_i), .src_stk_i(src_stk_i),
        .ac_en_i(ac_en_i), .cpl_i(cpl_i),
        .done_o(done_o), .fault_o(fault_o), .fault_code_o(fault_code_o),
        .flags_o(flags_o), .src_ptr_o(src_ptr_o), .dst_ptr_o(dst_ptr_o)
    );

    typedef struct packed {
        logic [31:0] sp;
        logic [31:0] dp;
        logic [5:0]  fl;
        logic        flt;
        logic [1:0]  code;
        logic [63:0] tag;
    } exp_t;

    exp_t        q[$];
    int          n_chk = 0;
    int          n_bad = 0;
    logic [5:0]  model_fl = 6'd0;
    bit          finished = 0;

    function automatic int nbytes(logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [5:0] mflags(int nb, logic [31:0] a, logic [31:0] b);
        longint unsigned m, ua, ub, res;
        int top;
        logic of_b, sf_b, zf_b, af_b, pf_b, cf_b;
        m   = (64'd1 << (8 * nb)) - 64'd1;
        ua  = {32'd0, a} & m;
        ub  = {32'd0, b} & m;
        res = (ua - ub) & m;
        top = 8 * nb - 1;
        cf_b = ua < ub;
        sf_b = ((res >> top) & 64'd1) != 0;
        zf_b = res == 0;
        of_b = ((((ua >> top) ^ (ub >> top)) & 64'd1) != 0) && (sf_b != (((ua >> top) & 64'd1) != 0));
        af_b = a[3:0] < b[3:0];
        pf_b = ($countones(res[7:0]) % 2) == 0;
        return {of_b, sf_b, zf_b, af_b, pf_b, cf_b};
    endfunction

    function automatic logic [31:0] mptr(logic [31:0] p, int nb, logic d, logic a32);
        logic [15:0] lo;
        if (a32) return d ? p - nb : p + nb;
        lo = d ? p[15:0] - 16'(nb) : p[15:0] + 16'(nb);
        return {p[31:16], lo};
    endfunction

    function automatic logic [1:0] mfault();
        int nb;
        longint unsigned es, ed;
        nb = nbytes(size_i);
        es = addr32_i ? {32'd0, src_ptr_i} : {48'd0, src_ptr_i[15:0]};
        ed = addr32_i ? {32'd0, dst_ptr_i} : {48'd0, dst_ptr_i[15:0]};
        if (src_null_i || dst_null_i) return 2'd1;
        if (es + nb - 1 > {32'd0, src_lim_i}) return src_stk_i ? 2'd2 : 2'd1;
        if (ed + nb - 1 > {32'd0, dst_lim_i}) return 2'd1;
        if (ac_en_i && cpl_i == 2'd3 && ((es % nb) != 0 || (ed % nb) != 0)) return 2'd3;
        return 2'd0;
    endfunction

    task automatic defaults();
        size_i = 2'd0; dir_i = 1'b0; addr32_i = 1'b1;
        opa_i = 32'd0; opb_i = 32'd0;
        src_ptr_i = 32'h0000_1000; dst_ptr_i = 32'h0000_2000;
        src_lim_i = 32'hFFFF_FFFF; dst_lim_i = 32'hFFFF_FFFF;
        src_null_i = 1'b0; dst_null_i = 1'b0; src_stk_i = 1'b0;
        ac_en_i = 1'b0; cpl_i = 2'd0;
    endtask

    // inputs are already set at a negedge; raise start and queue the expectation
    task automatic go(input logic [63:0] tag);
        exp_t e;
        int nb;
        nb = nbytes(size_i);
        e.code = mfault();
        e.flt  = e.code != 2'd0;
        e.tag  = tag;
        if (e.flt) begin
            e.sp = src_ptr_i;
            e.dp = dst_ptr_i;
        end else begin
            model_fl = mflags(nb, opa_i, opb_i);
            e.sp = mptr(src_ptr_i, nb, dir_i, addr32_i);
            e.dp = mptr(dst_ptr_i, nb, dir_i, addr32_i);
        end
        e.fl = model_fl;
        q.push_back(e);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        defaults();
    endtask

    // monitor: samples just after each rising edge
    always @(posedge clk) begin
        #1;
        if (!rst && !finished) begin
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (!done_o) begin
                    n_bad++;
                    $display("FAIL R9 [%s]: done_o=%0b expected 1", e.tag, done_o);
                end
                n_chk++;
                if (src_ptr_o !== e.sp || dst_ptr_o !== e.dp) begin
                    n_bad++;
                    $display("FAIL %s pointers: got %h/%h expected %h/%h",
                             e.tag, src_ptr_o, dst_ptr_o, e.sp, e.dp);
                end
                n_chk++;
                if (flags_o !== e.fl) begin
                    n_bad++;
                    $display("FAIL %s flags: got %b expected %b", e.tag, flags_o, e.fl);
                end
                n_chk++;
                if (fault_o !== e.flt || fault_code_o !== e.code) begin
                    n_bad++;
                    $display("FAIL %s fault: got %0b/%0d expected %0b/%0d",
                             e.tag, fault_o, fault_code_o, e.flt, e.code);
                end
            end else if (done_o) begin
                n_chk++;
                n_bad++;
                $display("FAIL R9: done_o=1 expected 0 with no request");
            end
        end
    end

    task automatic summary();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1;
        start_i = 1'b0;
        defaults();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (done_o !== 1'b0 || fault_o !== 1'b0 || fault_code_o !== 2'd0 ||
            flags_o !== 6'd0 || src_ptr_o !== 32'd0 || dst_ptr_o !== 32'd0) begin
            n_bad++;
            $display("FAIL R10: reset outputs got %b %b %0d %b %h %h expected all zero",
                     done_o, fault_o, fault_code_o, flags_o, src_ptr_o, dst_ptr_o);
        end

        // R1 R2: equal bytes -> ZF and PF
        opa_i = 32'h0000_0055; opb_i = 32'h0000_0055;
        go("R1eq");
        // R2 R3: 0x00-0x01 backward byte -> CF SF AF, PF (0xFF even)
        opa_i = 32'h0; opb_i = 32'h1; dir_i = 1'b1;
        go("R2bor");
        // R1: 0x80-0x01 -> OF, no CF, odd parity
        opa_i = 32'h80; opb_i = 32'h01;
        go("R1ovf");
        // R1 R3: word with junk above bit 15, forward step 2
        size_i = 2'd1; opa_i = 32'hABCD_1000; opb_i = 32'h1234_0001;
        go("R1word");
        // R1: dword 0x7FFFFFFF - 0xFFFFFFFF -> OF and CF
        size_i = 2'd2; opa_i = 32'h7FFF_FFFF; opb_i = 32'hFFFF_FFFF; dir_i = 1'b1;
        go("R3dw");
        // R3: size code 3 is a doubleword
        size_i = 2'd3; opa_i = 32'h1; opb_i = 32'h1;
        go("R3sz3");
        // R4: 16-bit forward wrap of source
        addr32_i = 1'b0; size_i = 2'd2; src_ptr_i = 32'h1234_FFFE; dst_ptr_i = 32'h0000_0100;
        dst_lim_i = 32'h0000_FFFF; opa_i = 32'h5; opb_i = 32'h9;
        go("R4fwd");
        // R4: 16-bit backward wrap of word
        addr32_i = 1'b0; size_i = 2'd1; dir_i = 1'b1; src_ptr_i = 32'h5555_0000;
        dst_ptr_i = 32'hAAAA_0001;
        go("R4bwd");
        // R5: null selector, flags and pointers frozen
        src_null_i = 1'b1; opa_i = 32'h1; opb_i = 32'h2;
        go("R5null");
        // R5 over R6: null plus overrun still general protection
        dst_null_i = 1'b1; src_stk_i = 1'b1; src_lim_i = 32'h0000_0010; src_ptr_i = 32'h20;
        go("R5prio");
        // R6 boundary: word ending exactly at the limit is fine
        size_i = 2'd1; dst_lim_i = 32'h0000_3001; dst_ptr_i = 32'h0000_3000;
        opa_i = 32'h3; opb_i = 32'h1;
        go("R6edge");
        // R6: one byte past limit on destination
        size_i = 2'd1; dst_lim_i = 32'h0000_3000; dst_ptr_i = 32'h0000_3000;
        go("R6dst");
        // R6: stack-segment source overrun -> code 2
        src_stk_i = 1'b1; src_lim_i = 32'h0000_1002; src_ptr_i = 32'h0000_1000; size_i = 2'd2;
        go("R6ss");
        // R7: misaligned word at user level
        size_i = 2'd1; src_ptr_i = 32'h0000_1001; ac_en_i = 1'b1; cpl_i = 2'd3;
        go("R7ac");
        // R7: same reference at privilege 0 -> no fault
        size_i = 2'd1; src_ptr_i = 32'h0000_1001; ac_en_i = 1'b1; cpl_i = 2'd0;
        opa_i = 32'h10; opb_i = 32'h10;
        go("R7cpl0");
        // R7: checking disabled at user level -> no fault
        size_i = 2'd2; dst_ptr_i = 32'h0000_2002; ac_en_i = 1'b0; cpl_i = 2'd3;
        opa_i = 32'h0; opb_i = 32'h8000_0000;
        go("R7off");
        // R8: alignment fault after a clean op keeps the flags just produced
        size_i = 2'd2; dst_ptr_i = 32'h0000_2002; ac_en_i = 1'b1; cpl_i = 2'd3;
        go("R8hold");
        repeat (3) @(negedge clk);
        summary();
    end
endmodule